// File: doc/BRIEF.md
# Watchdog Timer with Reset Pulse

This block is a host-programmable watchdog that counts down in whole seconds. A prescaler divides the system clock into a one-second tick, and the divide value is a parameter. The host sees one 8-bit control word. A write strobe with data loads the word, and a read port returns it. The word holds an enable bit, a read-only expiry flag and a 6-bit seconds count, which reads back live as the count falls.

When the count runs out, the block does three things:
- It raises a one-cycle `freq_revert` request. The frequency-select logic uses it to drop any software-chosen frequency and go back to the setting strapped on its pins at power-up.
- It pulls an open-drain reset line low for a fixed number of cycles. That width is the 4 ms window, and it is also a parameter.
- It sets the expiry flag, which stays readable until the host re-arms the watchdog.

A four-state controller sequences this:
- States: IDLE (stopped), RUN (counting), EXPIRE (single cycle that issues the revert request and starts the pulse) and HOLD (waits out the reset pulse).
- Transitions: *arm* (IDLE→RUN on a write with enable set), *disarm* (RUN→IDLE on a write with enable clear), *kick* (RUN→RUN on a write with enable set), *expiry* (RUN→EXPIRE on the last tick), *launch* (EXPIRE→HOLD), and *release* (HOLD→RUN if enable is set, HOLD→IDLE if not, once the pulse has ended).

Top module: `wdt_reset_gen`

## Requirements
- R1: After reset the read word is 0x00, `rst_pull_low` is 0 and `freq_revert` is 0, so the watchdog starts disabled.
- R2: The read word is {enable at bit 7, expiry flag at bit 6, live count at bits 5:0}. A write with bit 7 = 1 loads bits 5:0 into the count. Bit 6 of any write is ignored.
- R3: While enabled, the count falls by one every TICK_CYCLES clock cycles, measured from the arming write.
- R4: After arming with a count N ≥ 1, expiry happens exactly N·TICK_CYCLES cycles after the arming write.
- R5: A count of 0 with enable set expires on the first tick, TICK_CYCLES cycles after the write.
- R6: A write with bit 7 = 0 stops the watchdog. The count freezes, its bits 5:0 are ignored, and no expiry follows however long it waits.
- R7: A write with bit 7 = 1 while counting reloads the count and restarts the tick phase. Expiry then follows the new write by the full interval.
- R8: In the cycle of the revert request, the read word shows enable 0, flag 1 and count 0.
- R9: The expiry flag is cleared only by a write with bit 7 = 1. A write with bit 7 = 0 leaves it set.
- R10: `rst_pull_low` goes high in the cycle after the revert request and stays high for exactly PULSE_CYCLES cycles.
- R11: `freq_revert` is high for exactly one cycle per expiry, in the cycle after the clock edge that takes the last tick.
- R12: A write with bit 7 = 1 during the reset pulse does not shorten the pulse. Counting starts again one cycle after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the tick and the pulse width are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | One-cycle write strobe for the control word |
| host_wdata | input | 8 | Write data: bit 7 enable, bits 5:0 seconds |
| host_rdata | output | 8 | Read data: enable, expiry flag, live count |
| rst_pull_low | output | 1 | Open-drain enable: 1 pulls the reset line low, 0 leaves it floating |
| freq_revert | output | 1 | One-cycle request to return to the hardware-strapped frequency |

## Verification
The bench sweeps every start count from 0 to 5 and times expiry to the cycle against N·TICK_CYCLES, with a zero count treated as one tick. A design that counts one tick too many or too few, or that never fires on zero, misses the expected cycle. A kick one cycle before expiry catches a prescaler whose phase is not restarted: such a design fires early. A disarm with a nonzero seconds field catches a design that reloads the count while stopping, and waiting many ticks after the disarm exposes a counter that keeps running. A re-arm during the reset pulse checks two things: a truncated pulse shows up as a short low time, and a controller that loses the enable in HOLD never fires a second time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WD_WORD_W = 8;
    localparam int unsigned WD_SEC_W  = 6;

    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_RUN    = 2'd1,
        WD_EXPIRE = 2'd2,
        WD_HOLD   = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int unsigned TICK_CYCLES = 33_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && !restart && (phase_q == LAST);

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned PULSE_CYCLES = 132_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned PCW = $clog2(PULSE_CYCLES + 1);

    logic [PCW-1:0] left_q;
    logic           busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            left_q <= PCW'(PULSE_CYCLES - 1);
        end else if (busy_q) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;

    // independent up-counter measuring each low window
    logic [PCW:0] width_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (busy_q) begin
            width_q <= width_q + 1'b1;
        end else begin
            width_q <= '0;
        end
    end

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (width_q == (PCW+1)'(PULSE_CYCLES)));

    // R10
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                wr_enable,
    input  logic [WD_SEC_W-1:0] wr_secs,
    input  logic                tick,
    input  logic                pulse_busy,
    output logic                run,
    output logic                revert,
    output logic                en_q,
    output logic                flag_q,
    output logic [WD_SEC_W-1:0] cnt_q
);
    wd_state_e state_q, state_d;

    logic arm_wr, stop_wr, last_tick;

    assign arm_wr    = wr && wr_enable;
    assign stop_wr   = wr && !wr_enable;
    assign last_tick = (state_q == WD_RUN) && tick && (cnt_q <= WD_SEC_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (arm_wr) state_d = WD_RUN;                 // arm
            end
            WD_RUN: begin
                if (stop_wr)        state_d = WD_IDLE;        // disarm
                else if (last_tick) state_d = WD_EXPIRE;      // expiry
            end
            WD_EXPIRE: begin
                state_d = WD_HOLD;                            // launch
            end
            WD_HOLD: begin
                if (!pulse_busy) begin                        // release
                    state_d = (wr ? wr_enable : en_q) ? WD_RUN : WD_IDLE;
                end
            end
            default: state_d = WD_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run    = (state_q == WD_RUN);
        revert = (state_q == WD_EXPIRE);
    end

    // control word fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (wr)             en_q <= wr_enable;
            else if (last_tick) en_q <= 1'b0;

            if (arm_wr)         flag_q <= 1'b0;
            else if (last_tick) flag_q <= 1'b1;

            if (arm_wr) begin
                cnt_q <= wr_secs;
            end else if ((state_q == WD_RUN) && tick) begin
                cnt_q <= (cnt_q <= WD_SEC_W'(1)) ? '0 : cnt_q - 1'b1;
            end
        end
    end

    // R11
    revert_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        revert |=> !revert);

    // R8
    expire_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        revert |-> (flag_q && !en_q && (cnt_q == '0)));

    // R6
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr) |=> $stable(cnt_q));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !arm_wr) |=> flag_q);

    // R3
    tick_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en_q);

endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen
    import wdt_pkg::*;
#(
    parameter int unsigned TICK_CYCLES  = 33_000_000,
    parameter int unsigned PULSE_CYCLES = 132_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [WD_WORD_W-1:0] host_wdata,
    output logic [WD_WORD_W-1:0] host_rdata,
    output logic                 rst_pull_low,
    output logic                 freq_revert
);
    logic                run, tick, revert, busy, en_q, flag_q;
    logic [WD_SEC_W-1:0] cnt_q;
    logic                unused_wbit;

    assign unused_wbit = host_wdata[6];

    wdt_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (host_wr),
        .tick    (tick)
    );

    wdt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (host_wr),
        .wr_enable  (host_wdata[7]),
        .wr_secs    (host_wdata[WD_SEC_W-1:0]),
        .tick       (tick),
        .pulse_busy (busy),
        .run        (run),
        .revert     (revert),
        .en_q       (en_q),
        .flag_q     (flag_q),
        .cnt_q      (cnt_q)
    );

    wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (revert),
        .busy  (busy)
    );

    assign host_rdata   = {en_q, flag_q, cnt_q};
    assign rst_pull_low = busy;
    assign freq_revert  = revert;

    // R10
    revert_precedes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_revert |-> !rst_pull_low);

endmodule

// File: tb/sim_wdt_reset_gen.sv
module sim_wdt_reset_gen;
    localparam int D = 8;
    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    wire  [7:0] rd;
    wire        low;
    wire        rev;

    int checks = 0;
    int fails = 0;
    int rev_seen = 0;

    always #2 clk = ~clk;

    wdt_reset_gen #(.TICK_CYCLES(D), .PULSE_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(wr), .host_wdata(wd),
        .host_rdata(rd), .rst_pull_low(low), .freq_revert(rev)
    );

    always @(negedge clk) if (rev) rev_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] v);
        @(negedge clk); wr = 1'b1; wd = v;
        @(negedge clk); wr = 1'b0; wd = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rev(output int c);
        c = 0;
        do begin
            @(negedge clk); c++;
        end while (!rev && c < 5000);
    endtask

    // called at the negedge where rev was seen
    task automatic pulse_len(input string tag);
        int n;
        n = 0;
        @(negedge clk);
        chk({tag, " R11 revert gone"}, int'(rev), 0);
        chk({tag, " R10 pulse starts"}, int'(low), 1);
        while (low && n < 5000) begin
            n++; @(negedge clk);
        end
        chk({tag, " R10 pulse width"}, n, P);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int c;
        idle(3);
        // R1 reset state
        chk("R1 rdata", int'(rd), 0);
        chk("R1 pull", int'(low), 0);
        chk("R1 revert", int'(rev), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        chk("R1 rdata after release", int'(rd), 0);

        // R4 R5 sweep of start counts
        for (int n = 0; n <= 5; n++) begin
            write(8'h80 | 8'(n));
            chk("R2 armed word", int'(rd), 32'h80 | n);
            wait_rev(c);
            chk((n == 0) ? "R5 zero expiry" : "R4 expiry cycle", c, ((n == 0) ? 1 : n) * D);
            chk("R8 word at expiry", int'(rd), 32'h40);
            pulse_len("sweep");
            idle(2);
        end

        // R3 decrement per tick, R6 freeze
        write(8'h85);
        idle(D - 1);
        chk("R3 before tick", int'(rd), 32'h85);
        idle(1);
        chk("R3 first tick", int'(rd), 32'h84);
        idle(D);
        chk("R3 second tick", int'(rd), 32'h83);
        c = rev_seen;
        write(8'h3F);
        chk("R6 stopped word", int'(rd), 32'h03);
        idle(5 * D);
        chk("R6 count frozen", int'(rd), 32'h03);
        chk("R6 no expiry", rev_seen, c);

        // R9 flag semantics, R2 bit 6 ignored
        write(8'h81);
        wait_rev(c);
        chk("R4 one second", c, D);
        pulse_len("flag");
        idle(2);
        chk("R9 flag set", int'(rd), 32'h40);
        write(8'h00);
        chk("R9 flag kept by stop", int'(rd), 32'h40);
        write(8'h7F);
        chk("R6 secs ignored on stop", int'(rd), 32'h40);
        write(8'hC2);
        chk("R2 bit6 ignored R9 cleared", int'(rd), 32'h82);
        write(8'h00);
        chk("R6 stop keeps count", int'(rd), 32'h02);

        // R7 kick just before expiry
        write(8'h82);
        idle(2 * D - 3);
        c = rev_seen;
        write(8'h82);
        chk("R7 no early expiry", rev_seen, c);
        wait_rev(c);
        chk("R7 kick restarts interval", c, 2 * D);
        pulse_len("kick");
        idle(2);

        // R12 re-arm during pulse
        write(8'h81);
        wait_rev(c);
        chk("R4 before rearm", c, D);
        write(8'h82);
        chk("R12 rearm word", int'(rd), 32'h82);
        c = 0;
        while (low && c < 5000) begin
            c++; @(negedge clk);
        end
        chk("R12 pulse not cut", c, P - 1);
        wait_rev(c);
        chk("R12 restart after pulse", c, 2 * D + 1);
        pulse_len("rearm");
        idle(2);

        chk("R11 revert count", rev_seen, 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule